// File: doc/BRIEF.md
# Priority Nested Interrupt Controller

This block collects interrupt requests from peripherals, from a fixed set of core exception sources and from a low-priority software source. It presents one request at a time to a processor core, together with a vector address and the priority level of that request. Peripheral sources each carry a programmable level. Exception sources sit above all of them, and the software source sits below. A request is only presented when its level is strictly higher than the level the core is already servicing. This is how nesting works.

The core accepts a presented request with a one-cycle acknowledge pulse. The block then raises its current level to the accepted level and saves the previous level on a small internal stack. A one-cycle return pulse restores the saved level. Two fast slots can each be bound to any source number. A bound source wins ties at its level and is presented with a vector from a dedicated register instead of the table entry. The vector table base can be moved. A wake line tells the clock controller that enabled work is pending, whatever the current level is.

Top module: `prio_nest_intc`

## Requirements
- R1: After reset, irq_out, irq_fast and wake_req are low. Every peripheral priority field reads 3 (disabled). The vector base, the debug mask and both fast slot registers read 0.
- R2: Source numbers and levels are fixed as follows. Sources 0..3 are exception inputs, sources 4..6 are debug inputs, source 7 is the software input, and source 8+k is peripheral k. Each peripheral has a 2-bit field at bits 2k'+1:2k' of register 0x10+k/8, where k'=k mod 8. Field value 0, 1 or 2 gives level 0, 1 or 2, and value 3 disables the source. irq_level encodes the levels as 1=software, 2=level 0, 3=level 1, 4=level 2, 5=level 3.
- R3: Exception sources 0..3 are at level 3 and no mask affects them. Debug sources 4..6 are at level 3 and are blocked while their bit in mask register 0x05 (bits 2:0) is 1.
- R4: Source 7 is presented at the lowest level (code 1) and loses to any pending level-0 or higher source.
- R5: Among pending sources at the same level, the lowest source number is presented.
- R6: A request is presented only while its level is strictly above the current level. Outputs are registered and reflect the inputs and configuration sampled at the previous clock edge.
- R7: core_ack while irq_out is high sets the current level to the presented level and pushes the old level onto the stack. irq_out is low in the following cycle.
- R8: A core_rti pulse restores the most recently saved level. A core_rti pulse with an empty stack leaves the current level unchanged.
- R9: If core_ack (while irq_out is high) and core_rti arrive in the same cycle, the current level takes the presented level and the stack depth and contents do not change.
- R10: For a non-fast request, irq_vec equals the base register (0x00) plus twice the source number.
- R11: Registers 0x01 and 0x02 bind fast slots 0 and 1. In each, bit 15 is the enable and the low bits hold the source number. Registers 0x03 and 0x04 hold the matching vectors. A bound pending source wins at its level over unbound sources, and slot 0 beats slot 1. It is presented with its slot's vector and irq_fast high.
- R12: wake_req is combinational and high whenever any unmasked, enabled source is pending, regardless of the current level.
- R13: Every configuration register reads back on reg_rdata, combinationally from reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 4 | Level-3 exception requests, sources 0..3 |
| dbg_req | input | 3 | Level-3 debug requests, sources 4..6 |
| swlp_req | input | 1 | Lowest-level software request, source 7 |
| per_req | input | NUM_SRC | Peripheral requests, source 8+k |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| core_ack | input | 1 | Core accepts the presented request |
| core_rti | input | 1 | Core returns from a service routine |
| irq_out | output | 1 | Request to the core |
| irq_vec | output | 16 | Vector address of the presented request |
| irq_level | output | 3 | Level code of the presented request |
| irq_fast | output | 1 | Presented request comes from a fast slot |
| wake_req | output | 1 | Wake request to the clock controller |

## Verification
The functions that can collide are acknowledge and return. A core that chains from one handler into the next pulses core_ack and core_rti in the same cycle. The bench provokes this while a level-1 request preempts a level-0 service, so one entry sits on the stack. It then drops the request and returns once more. The correct result is that the saved idle level comes back and the pending level-0 source is presented again. If the combined cycle had pushed or popped, that source would stay hidden or the level would be wrong.

// File: rtl/pic_pkg.sv
// Shared constants for the priority nested interrupt controller.
// Assumes a fixed exception/debug/software source layout ahead of peripherals.
package pic_pkg;
    localparam int RANK_W   = 3;
    localparam int N_EXC    = 4;
    localparam int N_DBG    = 3;
    localparam int FIXED_N  = 8;   // exceptions, debug, software
    localparam int SW_ID    = 7;
    localparam int NUM_RANK = 5;   // software, L0, L1, L2, L3
    localparam int DEPTH_W  = 3;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;

    localparam logic [RANK_W-1:0] RK_NONE = 3'd0;
    localparam logic [RANK_W-1:0] RK_SW   = 3'd1;
    localparam logic [RANK_W-1:0] RK_L0   = 3'd2;
    localparam logic [RANK_W-1:0] RK_L1   = 3'd3;
    localparam logic [RANK_W-1:0] RK_L2   = 3'd4;
    localparam logic [RANK_W-1:0] RK_L3   = 3'd5;

    localparam logic [ADDR_W-1:0] A_BASE  = 5'h00;
    localparam logic [ADDR_W-1:0] A_FC0   = 5'h01;
    localparam logic [ADDR_W-1:0] A_FC1   = 5'h02;
    localparam logic [ADDR_W-1:0] A_FV0   = 5'h03;
    localparam logic [ADDR_W-1:0] A_FV1   = 5'h04;
    localparam logic [ADDR_W-1:0] A_DMASK = 5'h05;
    localparam int                A_PRIO  = 16;
endpackage

// File: rtl/pic_regs.sv
// Configuration register file: vector base, debug mask, two fast slots
// and packed 2-bit peripheral priority fields (8 per register).
// Assumes NUM_SRC <= 128 so the priority registers fit above 0x10.
module pic_regs
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ID_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [DATA_W-1:0]   vec_base,
    output logic [N_DBG-1:0]    dbg_mask,
    output logic [1:0]          fast_en,
    output logic [ID_W-1:0]     fast_id0,
    output logic [ID_W-1:0]     fast_id1,
    output logic [DATA_W-1:0]   fast_vec0,
    output logic [DATA_W-1:0]   fast_vec1,
    output logic [2*NUM_SRC-1:0] prio_flat
);
    localparam int PRIO_REGS = (NUM_SRC + 7) / 8;
    localparam int PRIO_BITS = PRIO_REGS * DATA_W;

    logic [PRIO_BITS-1:0] prio_q;

    // Register writes with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_base  <= '0;
            dbg_mask  <= '0;
            fast_en   <= '0;
            fast_id0  <= '0;
            fast_id1  <= '0;
            fast_vec0 <= '0;
            fast_vec1 <= '0;
            prio_q    <= '1;
        end else if (we) begin
            case (addr)
                A_BASE:  vec_base  <= wdata;
                A_FC0:   begin fast_en[0] <= wdata[DATA_W-1]; fast_id0 <= wdata[ID_W-1:0]; end
                A_FC1:   begin fast_en[1] <= wdata[DATA_W-1]; fast_id1 <= wdata[ID_W-1:0]; end
                A_FV0:   fast_vec0 <= wdata;
                A_FV1:   fast_vec1 <= wdata;
                A_DMASK: dbg_mask  <= wdata[N_DBG-1:0];
                default: begin
                    for (int g = 0; g < PRIO_REGS; g++) begin
                        if (addr == ADDR_W'(A_PRIO + g)) prio_q[g*DATA_W +: DATA_W] <= wdata;
                    end
                end
            endcase
        end
    end

    // Combinational read-back mux.
    always_comb begin
        rdata = '0;
        case (addr)
            A_BASE:  rdata = vec_base;
            A_FC0:   rdata = {fast_en[0], (DATA_W-1-ID_W)'(0), fast_id0};
            A_FC1:   rdata = {fast_en[1], (DATA_W-1-ID_W)'(0), fast_id1};
            A_FV0:   rdata = fast_vec0;
            A_FV1:   rdata = fast_vec1;
            A_DMASK: rdata = {(DATA_W-N_DBG)'(0), dbg_mask};
            default: begin
                for (int g = 0; g < PRIO_REGS; g++) begin
                    if (addr == ADDR_W'(A_PRIO + g)) rdata = prio_q[g*DATA_W +: DATA_W];
                end
            end
        endcase
    end

    assign prio_flat = prio_q[2*NUM_SRC-1:0];
endmodule

// File: rtl/pic_arb.sv
// Combinational arbiter: finds the highest pending rank, then the winner
// (fast slot 0, fast slot 1, else lowest source number) and compares the
// rank against the current service level. Rank 0 means not pending.
module pic_arb
    import pic_pkg::*;
#(
    parameter int N_ALL = 24,
    parameter int ID_W  = 5
) (
    input  logic [N_ALL*RANK_W-1:0] src_rank,
    input  logic [RANK_W-1:0]       cur_rank,
    input  logic [1:0]              fast_en,
    input  logic [ID_W-1:0]         fast_id0,
    input  logic [ID_W-1:0]         fast_id1,
    output logic                    win_valid,
    output logic [ID_W-1:0]         win_id,
    output logic [RANK_W-1:0]       win_rank,
    output logic                    win_fast,
    output logic                    win_slot
);
    logic [RANK_W-1:0] rk [N_ALL];
    logic              found;

    // Unpack the per-source ranks.
    always_comb begin
        for (int i = 0; i < N_ALL; i++) rk[i] = src_rank[i*RANK_W +: RANK_W];
    end

    // Highest rank, then tie-break by fast slot and lowest number.
    always_comb begin
        win_rank = RK_NONE;
        for (int i = 0; i < N_ALL; i++) begin
            if (rk[i] > win_rank) win_rank = rk[i];
        end
        win_id = '0;
        found  = 1'b0;
        for (int i = 0; i < N_ALL; i++) begin
            if (!found && win_rank != RK_NONE && rk[i] == win_rank) begin
                win_id = ID_W'(i);
                found  = 1'b1;
            end
        end
        win_fast = 1'b0;
        win_slot = 1'b0;
        if (fast_en[1] && int'(fast_id1) < N_ALL && win_rank != RK_NONE
            && rk[fast_id1] == win_rank) begin
            win_fast = 1'b1;
            win_slot = 1'b1;
            win_id   = fast_id1;
        end
        if (fast_en[0] && int'(fast_id0) < N_ALL && win_rank != RK_NONE
            && rk[fast_id0] == win_rank) begin
            win_fast = 1'b1;
            win_slot = 1'b0;
            win_id   = fast_id0;
        end
        win_valid = (win_rank > cur_rank);
    end
endmodule

// File: rtl/pic_lvl_stack.sv
// Current service level and the stack of interrupted levels.
// Assumes pushes only with a strictly higher level, so DEPTH entries suffice.
module pic_lvl_stack
    import pic_pkg::*;
#(
    parameter int DEPTH = NUM_RANK
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    input  logic [RANK_W-1:0]  new_rank,
    output logic [RANK_W-1:0]  cur_rank,
    output logic [DEPTH_W-1:0] depth
);
    logic [RANK_W-1:0] stk [DEPTH];

    // Push on accept, pop on return, replace level when both coincide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_rank <= RK_NONE;
            depth    <= '0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= RK_NONE;
        end else if (push && pop) begin
            cur_rank <= new_rank;
        end else if (push) begin
            if (int'(depth) < DEPTH) begin
                stk[depth] <= cur_rank;
                depth      <= depth + 1'b1;
            end
            cur_rank <= new_rank;
        end else if (pop && depth != '0) begin
            cur_rank <= stk[depth - 1'b1];
            depth    <= depth - 1'b1;
        end
    end
endmodule

// File: rtl/prio_nest_intc.sv
// Top of the priority nested interrupt controller. Maps every request to
// a rank, arbitrates, registers the presentation to the core and tracks
// the service level. Assumes level-sensitive requests held until serviced.
module prio_nest_intc
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_EXC-1:0]    exc_req,
    input  logic [N_DBG-1:0]    dbg_req,
    input  logic                swlp_req,
    input  logic [NUM_SRC-1:0]  per_req,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                core_ack,
    input  logic                core_rti,
    output logic                irq_out,
    output logic [DATA_W-1:0]   irq_vec,
    output logic [RANK_W-1:0]   irq_level,
    output logic                irq_fast,
    output logic                wake_req
);
    localparam int N_ALL = FIXED_N + NUM_SRC;
    localparam int ID_W  = $clog2(N_ALL);

    logic [DATA_W-1:0]       vec_base, fast_vec0, fast_vec1;
    logic [N_DBG-1:0]        dbg_mask;
    logic [1:0]              fast_en;
    logic [ID_W-1:0]         fast_id0, fast_id1;
    logic [2*NUM_SRC-1:0]    prio_flat;
    logic [N_ALL*RANK_W-1:0] src_rank;
    logic [N_ALL-1:0]        pend;
    logic                    win_valid, win_fast, win_slot;
    logic [ID_W-1:0]         win_id;
    logic [RANK_W-1:0]       win_rank, cur_rank;
    logic [DEPTH_W-1:0]      stk_depth;
    logic                    ack_ok;

    pic_regs #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .vec_base(vec_base), .dbg_mask(dbg_mask), .fast_en(fast_en),
        .fast_id0(fast_id0), .fast_id1(fast_id1), .fast_vec0(fast_vec0),
        .fast_vec1(fast_vec1), .prio_flat(prio_flat)
    );

    // Rank mapping for each source class.
    genvar gi;
    generate
        for (gi = 0; gi < N_EXC; gi++) begin : g_exc
            assign src_rank[gi*RANK_W +: RANK_W] = exc_req[gi] ? RK_L3 : RK_NONE;
        end
        for (gi = 0; gi < N_DBG; gi++) begin : g_dbg
            assign src_rank[(N_EXC+gi)*RANK_W +: RANK_W] =
                (dbg_req[gi] && !dbg_mask[gi]) ? RK_L3 : RK_NONE;
        end
        assign src_rank[SW_ID*RANK_W +: RANK_W] = swlp_req ? RK_SW : RK_NONE;
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_per
            assign src_rank[(FIXED_N+gi)*RANK_W +: RANK_W] =
                !per_req[gi]                  ? RK_NONE :
                (prio_flat[2*gi +: 2] == 2'd0) ? RK_L0 :
                (prio_flat[2*gi +: 2] == 2'd1) ? RK_L1 :
                (prio_flat[2*gi +: 2] == 2'd2) ? RK_L2 : RK_NONE;
        end
        for (gi = 0; gi < N_ALL; gi++) begin : g_pend
            assign pend[gi] = (src_rank[gi*RANK_W +: RANK_W] != RK_NONE);
        end
    endgenerate

    pic_arb #(.N_ALL(N_ALL), .ID_W(ID_W)) u_arb (
        .src_rank(src_rank), .cur_rank(cur_rank), .fast_en(fast_en),
        .fast_id0(fast_id0), .fast_id1(fast_id1), .win_valid(win_valid),
        .win_id(win_id), .win_rank(win_rank), .win_fast(win_fast), .win_slot(win_slot)
    );

    assign ack_ok = core_ack && irq_out;

    pic_lvl_stack #(.DEPTH(NUM_RANK)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(ack_ok), .pop(core_rti),
        .new_rank(irq_level), .cur_rank(cur_rank), .depth(stk_depth)
    );

    // Wake must work without a running clock, so it stays combinational.
    assign wake_req = |pend;

    // Registered presentation to the core; cleared in the accept cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || ack_ok) begin
            irq_out   <= 1'b0;
            irq_vec   <= '0;
            irq_level <= RK_NONE;
            irq_fast  <= 1'b0;
        end else begin
            irq_out   <= win_valid;
            irq_level <= win_valid ? win_rank : RK_NONE;
            irq_fast  <= win_valid && win_fast;
            irq_vec   <= !win_fast ? vec_base + DATA_W'({win_id, 1'b0}) :
                         (win_slot ? fast_vec1 : fast_vec0);
        end
    end
endmodule

// File: rtl/prio_nest_intc_chk.sv
// Assertion checker for prio_nest_intc, attached by bind below.
module prio_nest_intc_chk
    import pic_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               irq_out,
    input logic [RANK_W-1:0]  irq_level,
    input logic               irq_fast,
    input logic               wake_req,
    input logic               any_req,
    input logic [RANK_W-1:0]  cur_rank,
    input logic [DEPTH_W-1:0] depth,
    input logic               ack_ok,
    input logic               core_rti
);
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irq_level >= RK_SW && irq_level <= RK_L3)); // R2
    AST_NEST_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irq_level > cur_rank)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |=> !irq_out); // R7
    AST_ACK_TAKES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |=> (cur_rank == $past(irq_level))); // R7
    AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && !core_rti) |=> (depth == $past(depth) + 1'b1)); // R7
    AST_RTI_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rti && !ack_ok) |=> (cur_rank <= $past(cur_rank))); // R8
    AST_CHAIN_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && core_rti) |=> $stable(depth)); // R9
    AST_FAST_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> irq_out); // R11
    AST_WAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> any_req); // R12
endmodule

bind prio_nest_intc prio_nest_intc_chk chk_i (
    .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .irq_level(irq_level),
    .irq_fast(irq_fast), .wake_req(wake_req),
    .any_req((|exc_req) || (|dbg_req) || swlp_req || (|per_req)),
    .cur_rank(cur_rank), .depth(stk_depth), .ack_ok(ack_ok), .core_rti(core_rti)
);

// File: tb/prio_nest_intc_tb_top.sv
// Scoreboard bench: driver tasks queue expected presentations, a monitor
// compares them at the falling edge of the cycle they are due.
module prio_nest_intc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  exc_req = '0;
    logic [2:0]  dbg_req = '0;
    logic        swlp_req = 1'b0;
    logic [15:0] per_req = '0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        core_ack = 1'b0;
    logic        core_rti = 1'b0;
    logic        irq_out, irq_fast, wake_req;
    logic [15:0] irq_vec;
    logic [2:0]  irq_level;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int          cyc;
        bit          irq;
        logic [15:0] vec;
        logic [2:0]  lvl;
        bit          fast;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    prio_nest_intc #(.NUM_SRC(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .dbg_req(dbg_req),
        .swlp_req(swlp_req), .per_req(per_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_ack(core_ack),
        .core_rti(core_rti), .irq_out(irq_out), .irq_vec(irq_vec),
        .irq_level(irq_level), .irq_fast(irq_fast), .wake_req(wake_req)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Monitor: compare due items against the registered outputs.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            exp_t it;
            it = sbq.pop_front();
            if (!it.irq) begin
                chk(irq_out == 1'b0, it.tag, {31'd0, irq_out}, 32'd0);
            end else begin
                chk(irq_out == 1'b1 && irq_vec == it.vec && irq_level == it.lvl && irq_fast == it.fast,
                    it.tag, {11'd0, irq_fast, irq_level, irq_out, irq_vec},
                    {11'd0, it.fast, it.lvl, 1'b1, it.vec});
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver: queue the expectation for the next edge, then advance.
    task automatic step_exp(input bit irq, input logic [15:0] vec, input logic [2:0] lvl,
                            input bit fast, input string tag);
        exp_t it;
        it.cyc = cyc + 1; it.irq = irq; it.vec = vec; it.lvl = lvl; it.fast = fast; it.tag = tag;
        sbq.push_back(it);
        tick();
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic pulse_rti();
        core_rti = 1'b1;
        tick();
        core_rti = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(irq_out == 1'b0, "R1 irq_out after reset", {31'd0, irq_out}, 0);
        chk(wake_req == 1'b0, "R1 wake after reset", {31'd0, wake_req}, 0);
        reg_addr = 5'h10; #1;
        chk(reg_rdata == 16'hFFFF, "R1 priority fields disabled", reg_rdata, 16'hFFFF);
        reg_addr = 5'h05; #1;
        chk(reg_rdata == 16'h0000, "R1 debug mask", reg_rdata, 0);

        // R2 disabled peripheral is never presented and does not wake
        per_req[0] = 1'b1; #1;
        chk(wake_req == 1'b0, "R12 disabled source no wake", {31'd0, wake_req}, 0);
        step_exp(0, 0, 0, 0, "R2 disabled source");
        per_req[0] = 1'b0;

        wr(5'h00, 16'h0100);
        wr(5'h10, 16'hFFC5);   // src0,1 -> L1, src2 -> L0
        reg_addr = 5'h10; #1;
        chk(reg_rdata == 16'hFFC5, "R13 priority readback", reg_rdata, 16'hFFC5);

        per_req = 16'h0006;
        step_exp(1, 16'h0112, 3'd3, 0, "R10 vector of source 9");
        per_req = 16'h0007;
        step_exp(1, 16'h0110, 3'd3, 0, "R5 lowest number wins");
        chk(wake_req == 1'b1, "R12 wake pending", {31'd0, wake_req}, 1);

        core_ack = 1'b1;
        step_exp(0, 0, 0, 0, "R7 irq drops after ack");
        core_ack = 1'b0;
        step_exp(0, 0, 0, 0, "R6 equal level not presented");
        chk(wake_req == 1'b1, "R12 wake regardless of level", {31'd0, wake_req}, 1);

        wr(5'h10, 16'hFF85);   // src3 -> L2
        per_req[3] = 1'b1;
        step_exp(1, 16'h0116, 3'd4, 0, "R6 higher level preempts");
        core_ack = 1'b1;
        step_exp(0, 0, 0, 0, "R7 ack level 2");
        core_ack = 1'b0;

        exc_req = 4'b0100; dbg_req = 3'b001;
        step_exp(1, 16'h0104, 3'd5, 0, "R3 exception beats debug");
        exc_req = 4'b0000;
        wr(5'h05, 16'h0001);
        step_exp(0, 0, 0, 0, "R3 debug masked");
        wr(5'h05, 16'h0000);
        step_exp(1, 16'h0108, 3'd5, 0, "R3 debug unmasked");
        dbg_req = 3'b000;
        wr(5'h05, 16'h0007);
        exc_req = 4'b0001;
        step_exp(1, 16'h0100, 3'd5, 0, "R3 exception ignores mask");
        core_ack = 1'b1;
        step_exp(0, 0, 0, 0, "R7 ack level 3");
        core_ack = 1'b0;
        exc_req = 4'b0000;

        // unwind: 5 -> 4 -> 3 -> idle
        pulse_rti();
        step_exp(0, 0, 0, 0, "R8 back to level 2");
        per_req[3] = 1'b0;
        pulse_rti();
        step_exp(0, 0, 0, 0, "R8 back to level 1");
        per_req[1:0] = 2'b00;
        pulse_rti();
        step_exp(1, 16'h0114, 3'd2, 0, "R8 restored to idle");

        // R9 accept and return in one cycle
        core_ack = 1'b1;
        step_exp(0, 0, 0, 0, "R7 ack level 0");
        core_ack = 1'b0;
        per_req[0] = 1'b1;
        step_exp(1, 16'h0110, 3'd3, 0, "R6 level 1 over level 0 service");
        core_ack = 1'b1; core_rti = 1'b1;
        step_exp(0, 0, 0, 0, "R9 chained accept");
        core_ack = 1'b0; core_rti = 1'b0;
        per_req[0] = 1'b0;
        pulse_rti();
        step_exp(1, 16'h0114, 3'd2, 0, "R9 stack unchanged by chain");

        per_req[2] = 1'b0; swlp_req = 1'b1;
        step_exp(1, 16'h010E, 3'd1, 0, "R4 software level presented");
        pulse_rti();
        step_exp(1, 16'h010E, 3'd1, 0, "R8 empty-stack return ignored");
        per_req[2] = 1'b1;
        step_exp(1, 16'h0114, 3'd2, 0, "R4 software below level 0");
        per_req[2] = 1'b0; swlp_req = 1'b0;

        // R11 fast slots
        wr(5'h01, 16'h8009);
        wr(5'h03, 16'h1111);
        wr(5'h02, 16'h800B);
        wr(5'h04, 16'h2222);
        reg_addr = 5'h01; #1;
        chk(reg_rdata == 16'h8009, "R13 fast slot readback", reg_rdata, 16'h8009);
        per_req = 16'h0003;
        step_exp(1, 16'h1111, 3'd3, 1, "R11 fast source wins tie");
        per_req[3] = 1'b1;
        step_exp(1, 16'h2222, 3'd4, 1, "R11 slot 1 vector");
        wr(5'h02, 16'h8008);
        per_req[3] = 1'b0;
        step_exp(1, 16'h1111, 3'd3, 1, "R11 slot 0 over slot 1");
        wr(5'h01, 16'h0000);
        wr(5'h02, 16'h0000);
        step_exp(1, 16'h0110, 3'd3, 0, "R11 slots disabled");
        per_req = '0;

        // R12 masked or disabled sources do not wake
        dbg_req = 3'b001; #1;
        chk(wake_req == 1'b0, "R12 masked debug no wake", {31'd0, wake_req}, 0);
        dbg_req = 3'b000; per_req[5] = 1'b1; #1;
        chk(wake_req == 1'b0, "R12 disabled peripheral no wake", {31'd0, wake_req}, 0);
        per_req[5] = 1'b0; swlp_req = 1'b1; #1;
        chk(wake_req == 1'b1, "R12 software wakes", {31'd0, wake_req}, 1);
        swlp_req = 1'b0;

        // R10 relocated base
        wr(5'h00, 16'h4000);
        per_req[2] = 1'b1;
        step_exp(1, 16'h4014, 3'd2, 0, "R10 relocated base");
        per_req = '0;

        repeat (3) tick();
        chk(sbq.size() == 0, "R6 scoreboard drained", sbq.size(), 0);
        summary();
        $finish;
    end
endmodule